// File: doc/BRIEF.md
# NAND Sector Hamming Parity Generator

This block watches the data bus of a NAND flash interface and builds a 24-bit Hamming-style parity code over one sector while the bytes pass by. For every power-of-two granularity, from single bits within a byte up to halves of the sector, it keeps two parity terms. One covers the bits whose address bit is one and the other covers the bits whose address bit is zero. Software or a correction engine elsewhere compares this code with the one stored in the spare area and locates single-bit errors from the difference.

The host pulses a clear before each sector and sets the enable, the chip select to follow, the bus width (8-bit or 16-bit) and a sector size field. Beats for other chip selects are ignored. When the programmed number of bytes has been absorbed, the block stops accumulating and holds its result until the next clear. The result is available as a 32-bit raw word and as a packed, non-inverted 3-byte code.

Top module: `nand_ecc_gen`

## Requirements
- R1: After reset `raw_o`, `code_o` and `done_o` are all zero.
- R2: Column terms: for k in 0..2, odd term k (raw bit 16+k) is the XOR of every absorbed data bit whose bit-in-byte index has bit k set, and even term k (raw bit k) is the XOR of those with bit k clear.
- R3: Line terms: for j in 0..8, odd term 3+j (raw bit 19+j) is the XOR of all bits of the bytes whose byte address has bit j set, and even term 3+j (raw bit 3+j) covers the bytes with bit j clear. Raw bits 15:12 and 31:28 read zero.
- R4: `code_o[7:0]` = raw[7:0], `code_o[15:8]` = raw[23:16], `code_o[19:16]` = raw[11:8], `code_o[23:20]` = raw[27:24]. The code is not inverted.
- R5: With `cfg_wide_i`=1 each beat carries two bytes, `beat_data_i[7:0]` at address n and `beat_data_i[15:8]` at address n+1, and the address advances by 2. With `cfg_wide_i`=0 only `beat_data_i[7:0]` is used and the address advances by 1.
- R6: A beat is absorbed only when `beat_vld_i`=1, `cfg_en_i`=1 and `beat_cs_i` equals `cfg_cs_i`. Any other beat leaves `raw_o` and the byte count unchanged.
- R7: The sector length is (`size_field_i`+1)*2 bytes. `done_o` goes high in the cycle after the beat that reaches it. After that, further beats are ignored and `raw_o` holds.
- R8: A `clr_i` pulse zeroes the parity terms, the byte count and `done_o`. A beat in the same cycle as the clear is dropped.
- R9: A sector of all 0xFF bytes, in either bus width, gives an all-zero code.
- R10: The effect of an absorbed beat is visible on `raw_o` and `code_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Clears the accumulator and the byte count |
| cfg_en_i | input | 1 | Accumulation enable |
| cfg_cs_i | input | 3 | Chip select to follow |
| cfg_wide_i | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| size_field_i | input | 8 | Sector size as bytes/2 - 1 |
| beat_vld_i | input | 1 | Data beat present on the bus |
| beat_cs_i | input | 3 | Chip select of the current beat |
| beat_data_i | input | 16 | Bus data, low byte first |
| raw_o | output | 32 | Even terms at bits 11:0, odd terms at bits 27:16 |
| code_o | output | 24 | Packed 3-byte code |
| done_o | output | 1 | Sector complete, result frozen |

## Verification
Every result here sits exactly one register behind its cause: a beat or clear driven before edge n shows on `raw_o`, `code_o` and `done_o` after edge n. The bench drives on falling edges and samples on the falling edge after the capturing rising edge. For a whole sector this means the falling edge at which the valid strobe is released after the last beat. Expected codes come from a bench model that walks the byte array bit by bit. Rejected beats, with a wrong chip select or arriving after completion, are checked by comparing `raw_o` before and after them.

// File: rtl/nand_ecc_pkg.sv
`timescale 1ns/1ps
package nand_ecc_pkg;
  localparam int COL_TERMS  = 3;
  localparam int LINE_TERMS = 9;
  localparam int TERMS      = COL_TERMS + LINE_TERMS;
  localparam int BUS_LANES  = 2;
  localparam int ODD_BASE   = 16;

  typedef struct packed {
    logic [TERMS-1:0] odd;
    logic [TERMS-1:0] even;
  } par_t;

  function automatic logic [7:0] col_mask(input int k);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = ((i >> k) & 1) == 1;
    return m;
  endfunction

  function automatic logic [31:0] raw_of(input par_t p);
    logic [31:0] r;
    r = '0;
    r[TERMS-1:0] = p.even;
    r[ODD_BASE +: TERMS] = p.odd;
    return r;
  endfunction
endpackage

// File: rtl/nand_ecc_byte_term.sv
`timescale 1ns/1ps
module nand_ecc_byte_term
  import nand_ecc_pkg::*;
#(
  parameter int ADDR_W = LINE_TERMS
) (
  input  logic              en_i,
  input  logic [7:0]        byte_i,
  input  logic [ADDR_W-1:0] addr_i,
  output par_t              term_o
);
  logic [7:0] b;
  logic       row_par;

  assign b       = en_i ? byte_i : 8'h00;
  assign row_par = ^b;

  for (genvar k = 0; k < COL_TERMS; k++) begin : g_col
    localparam logic [7:0] MaskOdd = col_mask(k);
    assign term_o.odd[k]  = ^(b & MaskOdd);
    assign term_o.even[k] = ^(b & ~MaskOdd);
  end

  for (genvar j = 0; j < ADDR_W; j++) begin : g_line
    assign term_o.odd[COL_TERMS+j]  = row_par & addr_i[j];
    assign term_o.even[COL_TERMS+j] = row_par & ~addr_i[j];
  end
endmodule

// File: rtl/nand_ecc_sector_cnt.sv
`timescale 1ns/1ps
module nand_ecc_sector_cnt #(
  parameter int ADDR_W = 9,
  parameter int FIELD_W = ADDR_W - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               adv_i,
  input  logic               wide_i,
  input  logic [FIELD_W-1:0] size_field_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               done_o
);
  localparam int CNT_W = ADDR_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt, limit;
  logic             done_q;

  assign limit   = CNT_W'({size_field_i, 1'b0}) + CNT_W'(2);
  assign cnt_nxt = cnt_q + (wide_i ? CNT_W'(2) : CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (adv_i) begin
      cnt_q  <= cnt_nxt;
      done_q <= (cnt_nxt >= limit);
    end
  end

  assign addr_o = cnt_q[ADDR_W-1:0];
  assign done_o = done_q;
endmodule

// File: rtl/nand_ecc_accum.sv
`timescale 1ns/1ps
module nand_ecc_accum
  import nand_ecc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  input  par_t term_i,
  output par_t acc_o
);
  par_t acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (adv_i) acc_q <= acc_q ^ term_i;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/nand_ecc_pack.sv
`timescale 1ns/1ps
module nand_ecc_pack (
  input  logic [31:0] raw_i,
  output logic [23:0] code_o
);
  assign code_o[7:0]   = raw_i[7:0];
  assign code_o[15:8]  = raw_i[23:16];
  assign code_o[19:16] = raw_i[11:8];
  assign code_o[23:20] = raw_i[27:24];
endmodule

// File: rtl/nand_ecc_gen.sv
`timescale 1ns/1ps
module nand_ecc_gen
  import nand_ecc_pkg::*;
#(
  parameter int CS_W = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      cfg_en_i,
  input  logic [CS_W-1:0]           cfg_cs_i,
  input  logic                      cfg_wide_i,
  input  logic [LINE_TERMS-2:0]     size_field_i,
  input  logic                      beat_vld_i,
  input  logic [CS_W-1:0]           beat_cs_i,
  input  logic [8*BUS_LANES-1:0]    beat_data_i,
  output logic [31:0]               raw_o,
  output logic [23:0]               code_o,
  output logic                      done_o
);
  localparam int ADDR_W = LINE_TERMS;

  logic              accept;
  logic [ADDR_W-1:0] base_addr;
  par_t              lane_term [BUS_LANES];
  par_t              beat_term;
  par_t              acc;

  assign accept = beat_vld_i & cfg_en_i & (beat_cs_i == cfg_cs_i) & ~done_o & ~clr_i;

  nand_ecc_sector_cnt #(.ADDR_W(ADDR_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .adv_i       (accept),
    .wide_i      (cfg_wide_i),
    .size_field_i(size_field_i),
    .addr_o      (base_addr),
    .done_o      (done_o)
  );

  for (genvar l = 0; l < BUS_LANES; l++) begin : g_lane
    logic lane_en;
    if (l == 0) begin : g_first
      assign lane_en = 1'b1;
    end else begin : g_extra
      assign lane_en = cfg_wide_i;
    end
    nand_ecc_byte_term #(.ADDR_W(ADDR_W)) u_term (
      .en_i  (lane_en),
      .byte_i(beat_data_i[8*l +: 8]),
      .addr_i(base_addr + ADDR_W'(l)),
      .term_o(lane_term[l])
    );
  end

  always_comb begin
    beat_term = '0;
    for (int l = 0; l < BUS_LANES; l++) beat_term = beat_term ^ lane_term[l];
  end

  nand_ecc_accum u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .adv_i (accept),
    .term_i(beat_term),
    .acc_o (acc)
  );

  assign raw_o = raw_of(acc);

  nand_ecc_pack u_pack (
    .raw_i (raw_o),
    .code_o(code_o)
  );
endmodule

// File: rtl/nand_ecc_gen_chk.sv
`timescale 1ns/1ps
module nand_ecc_gen_chk #(
  parameter int CS_W = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            clr_i,
  input logic            cfg_en_i,
  input logic [CS_W-1:0] cfg_cs_i,
  input logic            beat_vld_i,
  input logic [CS_W-1:0] beat_cs_i,
  input logic [31:0]     raw_o,
  input logic            done_o
);
  AST_CLEAR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (raw_o == 32'h0 && !done_o)); // R8

  AST_DONE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_i) |=> (done_o && $stable(raw_o))); // R7

  AST_BEAT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && (!beat_vld_i || !cfg_en_i || beat_cs_i != cfg_cs_i))
      |=> ($stable(raw_o) && $stable(done_o))); // R6

  AST_PAIR_BALANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((raw_o[11:0] ^ raw_o[27:16]) == 12'h000 ||
     (raw_o[11:0] ^ raw_o[27:16]) == 12'hfff)); // R3

  AST_SPARE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_o[15:12] == 4'h0 && raw_o[31:28] == 4'h0)); // R3
endmodule

bind nand_ecc_gen nand_ecc_gen_chk #(.CS_W(CS_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_i     (clr_i),
  .cfg_en_i  (cfg_en_i),
  .cfg_cs_i  (cfg_cs_i),
  .beat_vld_i(beat_vld_i),
  .beat_cs_i (beat_cs_i),
  .raw_o     (raw_o),
  .done_o    (done_o)
);

// File: tb/nand_ecc_gen_tb.sv
`timescale 1ns/1ps
module nand_ecc_gen_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0;
  logic        cfg_en_i = 1'b1;
  logic [2:0]  cfg_cs_i = 3'd2;
  logic        cfg_wide_i = 1'b0;
  logic [7:0]  size_field_i = 8'd255;
  logic        beat_vld_i = 1'b0;
  logic [2:0]  beat_cs_i = 3'd2;
  logic [15:0] beat_data_i = '0;
  logic [31:0] raw_o;
  logic [23:0] code_o;
  logic        done_o;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] mem [512];

  always #10 clk = ~clk;

  nand_ecc_gen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr_i), .cfg_en_i(cfg_en_i),
    .cfg_cs_i(cfg_cs_i), .cfg_wide_i(cfg_wide_i), .size_field_i(size_field_i),
    .beat_vld_i(beat_vld_i), .beat_cs_i(beat_cs_i), .beat_data_i(beat_data_i),
    .raw_o(raw_o), .code_o(code_o), .done_o(done_o)
  );

  function automatic logic [31:0] model(input int n);
    logic [11:0] ev, od;
    ev = '0; od = '0;
    for (int a = 0; a < n; a++)
      for (int i = 0; i < 8; i++)
        if (mem[a][i]) begin
          for (int k = 0; k < 3; k++)
            if ((i >> k) & 1) od[k] ^= 1'b1; else ev[k] ^= 1'b1;
          for (int j = 0; j < 9; j++)
            if ((a >> j) & 1) od[3+j] ^= 1'b1; else ev[3+j] ^= 1'b1;
        end
    return {4'h0, od, 4'h0, ev};
  endfunction

  function automatic logic [23:0] pack(input logic [31:0] r);
    return {r[27:24], r[11:8], r[23:16], r[7:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear();
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
  endtask

  task automatic beat(input logic [15:0] d, input logic [2:0] cs);
    @(negedge clk);
    beat_vld_i = 1'b1; beat_data_i = d; beat_cs_i = cs;
  endtask

  task automatic idle();
    @(negedge clk); beat_vld_i = 1'b0;
  endtask

  // streams mem[0..n-1]; noise inserts beats for another chip select
  task automatic run_sector(input int n, input bit wide, input bit noise);
    cfg_wide_i = wide;
    clear();
    for (int a = 0; a < n; a += (wide ? 2 : 1)) begin
      if (noise && ($urandom % 4 == 0)) beat(16'($urandom), cfg_cs_i ^ 3'd5);
      beat(wide ? {mem[a+1], mem[a]} : {8'h00, mem[a]}, cfg_cs_i);
    end
    idle();
  endtask

  task automatic check_all(input string req, input int n, input logic exp_done);
    logic [31:0] e;
    e = model(n);
    check({req, " raw"}, raw_o, e);
    check("R4 code", {8'h0, code_o}, {8'h0, pack(e)});
    check({req, " done"}, {31'h0, done_o}, {31'h0, exp_done});
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] hold;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    // R1
    check("R1 raw", raw_o, 32'h0);
    check("R1 code", {8'h0, code_o}, 32'h0);
    check("R1 done", {31'h0, done_o}, 32'h0);
    rst_ni = 1'b1;

    // R10: single byte, result one cycle later
    for (int a = 0; a < 512; a++) mem[a] = 8'h00;
    mem[0] = 8'h01;
    clear();
    beat(16'h0001, cfg_cs_i);
    @(negedge clk); beat_vld_i = 1'b0;
    check("R10 latency", raw_o, 32'h0000_0fff);

    // R2 R3: single set bits at chosen positions
    for (int t = 0; t < 3; t++) begin
      int pa;
      int pb;
      for (int a = 0; a < 512; a++) mem[a] = 8'h00;
      pa = (t == 0) ? 9'h15a : ((t == 1) ? 9'h1ff : 9'h0a5);
      pb = (t == 0) ? 5 : ((t == 1) ? 7 : 2);
      mem[pa][pb] = 1'b1;
      run_sector(512, 1'b0, 1'b0);
      check_all("R2 R3 single bit", 512, 1'b1);
    end

    // R6 R7: random 8-bit sector with other-CS beats interleaved
    for (int a = 0; a < 512; a++) mem[a] = 8'($urandom);
    run_sector(512, 1'b0, 1'b1);
    check_all("R6 R7 random 8-bit", 512, 1'b1);

    // R5: random 16-bit sectors
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 512; a++) mem[a] = 8'($urandom);
      run_sector(512, 1'b1, s == 1);
      check_all("R5 random 16-bit", 512, 1'b1);
    end

    // R9: erased sector, both widths
    for (int a = 0; a < 512; a++) mem[a] = 8'hff;
    run_sector(512, 1'b0, 1'b0);
    check("R9 erased 8-bit", {8'h0, code_o}, 32'h0);
    run_sector(512, 1'b1, 1'b0);
    check("R9 erased 16-bit", {8'h0, code_o}, 32'h0);

    // R7: short sector (field 3 -> 8 bytes), extra beats ignored
    size_field_i = 8'd3;
    for (int a = 0; a < 512; a++) mem[a] = 8'($urandom);
    cfg_wide_i = 1'b0;
    clear();
    for (int a = 0; a < 7; a++) beat({8'h00, mem[a]}, cfg_cs_i);
    idle();
    check("R7 not done before last byte", {31'h0, done_o}, 32'h0);
    beat({8'h00, mem[7]}, cfg_cs_i);
    idle();
    check_all("R7 short sector", 8, 1'b1);
    hold = raw_o;
    for (int a = 0; a < 5; a++) beat(16'($urandom) | 16'h0001, cfg_cs_i);
    idle();
    check("R7 beats after done ignored", raw_o, hold);
    check("R7 done held", {31'h0, done_o}, 32'h1);
    size_field_i = 8'd255;

    // R6: disabled block ignores beats
    clear();
    cfg_en_i = 1'b0;
    for (int a = 0; a < 4; a++) beat(16'h00ff, cfg_cs_i);
    idle();
    check("R6 disabled", raw_o, 32'h0);
    cfg_en_i = 1'b1;

    // R8: clear wins over a beat in the same cycle; clear after done
    @(negedge clk);
    clr_i = 1'b1; beat_vld_i = 1'b1; beat_data_i = 16'h0001; beat_cs_i = cfg_cs_i;
    @(negedge clk);
    clr_i = 1'b0; beat_vld_i = 1'b0;
    check("R8 beat with clear dropped", raw_o, 32'h0);
    for (int a = 0; a < 512; a++) mem[a] = 8'($urandom);
    run_sector(512, 1'b1, 1'b0);
    clear();
    check("R8 clear raw", raw_o, 32'h0);
    check("R8 clear done", {31'h0, done_o}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule